// File: doc/BRIEF.md
# Serial Slave Byte Transceiver with Busy Handshake

This block is the slave end of a synchronous serial link whose clock belongs entirely to an external master. On each rising edge of the master's clock it captures one bit from the data-in pin and moves its transmit register along by one bit. Eight edges make a full-duplex byte exchange: one byte is received and one byte is sent out, both most-significant bit first. The block never generates a serial clock.

The serial clock and data are brought into the system clock domain through a synchroniser chain, and edges are found there. After the eighth accepted edge the block presents the received byte with a one-cycle strobe and pulls its active-low busy pin. Busy tells the master to pause while the local logic decodes the byte and stages the next transmit byte. Busy ends early when local logic raises a done input. Otherwise it ends on its own after a bounded number of cycles. Serial clock edges that arrive while busy is held are discarded. A synchronous frame-clear input puts the bit position back to the start of a frame.

Top module: `sslave_xcvr`

## Requirements
- R1: After eight accepted rising serial-clock edges, `rx_valid` is high for exactly one clock cycle. In that cycle `rx_byte` holds the eight `sdi` samples, with the first sample in bit 7 and the last sample in bit 0.
- R2: When `tx_load` is accepted, `sdo` presents `tx_byte[7]`. Each accepted rising edge then moves the next lower bit onto `sdo`, so the master sees bits 7 down to 0 in order.
- R3: `busy_n` goes low in the same cycle that `rx_valid` is high. That cycle is SYNC_STAGES+1 system clocks after the serial-clock rise of the eighth bit.
- R4: Without `done`, `busy_n` stays low for exactly BUSY_MAX cycles and never for longer.
- R5: When `done` is high while `busy_n` is low, `busy_n` returns high on the next cycle.
- R6: A rising serial-clock edge seen while busy is held is discarded. It neither advances the bit position nor shifts either data register.
- R7: `tx_load` is accepted only when the bit position is at the start of a frame and no edge is accepted in the same cycle. A load in the middle of a frame has no effect on the bits sent.
- R8: `frame_clr` returns the bit position to the start of a frame and releases busy. A frame that follows it is received intact.
- R9: After reset, `busy_n` is high, `rx_valid` is low and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in, sampled on the sclk rising edge |
| sdo | output | 1 | Serial data out, most-significant bit first |
| busy_n | output | 1 | Active-low flow-control handshake to the master |
| tx_load | input | 1 | Loads tx_byte into the transmit register |
| tx_byte | input | 8 | Byte to be sent in the next frame |
| rx_valid | output | 1 | One-cycle strobe marking a received byte |
| rx_byte | output | 8 | Last received byte |
| done | input | 1 | Local processing finished; releases busy |
| frame_clr | input | 1 | Synchronous return to the start of a frame |

## Verification
The hardest case to create is a serial clock edge that lands inside the busy window, because a well-behaved master never produces one. The frame task can run in a mode that lowers and raises `sclk` again as soon as busy is first seen. Synchroniser latency then makes the edge reach the core while busy is still held. The byte received in the next frame, and the strobe count, show whether that edge was discarded. A mid-frame `tx_load` and a `frame_clr` issued partway through a byte are driven the same way: partial frames are built from single bit steps.

// File: rtl/sst_pkg.sv
package sst_pkg;
    parameter int FRAME_BITS = 8;
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] rx_sh;
        logic [FRAME_BITS-1:0] tx_sh;
        logic [FRAME_BITS-1:0] rx_hold;
        logic                  rx_vld;
        logic                  prev;
    } core_state_t;
endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar w = 0; w < WIDTH; w++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[w]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign dout[w] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sst_shift_core.sv
module sst_shift_core
    import sst_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    input  logic                  busy_i,
    input  logic                  clr_i,
    input  logic                  tx_load_i,
    input  logic [FRAME_BITS-1:0] tx_byte_i,
    output logic                  frame_end_o,
    output logic                  sdo_o,
    output logic                  rx_valid_o,
    output logic [FRAME_BITS-1:0] rx_byte_o
);
    core_state_t st_d, st_q;
    logic rise, acc;

    always_comb begin
        rise        = sclk_s & ~st_q.prev;
        acc         = rise & ~busy_i;
        st_d        = st_q;
        st_d.prev   = sclk_s;
        st_d.rx_vld = 1'b0;
        frame_end_o = 1'b0;
        if (clr_i) begin
            st_d.cnt   = '0;
            st_d.rx_sh = '0;
        end else if (acc) begin
            st_d.rx_sh = {st_q.rx_sh[FRAME_BITS-2:0], sdi_s};
            st_d.tx_sh = {st_q.tx_sh[FRAME_BITS-2:0], 1'b0};
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt     = '0;
                st_d.rx_vld  = 1'b1;
                st_d.rx_hold = {st_q.rx_sh[FRAME_BITS-2:0], sdi_s};
                frame_end_o  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (tx_load_i && st_q.cnt == '0) begin
            st_d.tx_sh = tx_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o      = st_q.tx_sh[FRAME_BITS-1];
    assign rx_valid_o = st_q.rx_vld;
    assign rx_byte_o  = st_q.rx_hold;

    assert_rx_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && st_q.cnt == LAST_BIT && !clr_i) |=>
            (rx_valid_o && rx_byte_o == {$past(st_q.rx_sh[FRAME_BITS-2:0]), $past(sdi_s)}));

    assert_tx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_i && st_q.cnt == '0 && !acc && !clr_i) |=> (sdo_o == $past(tx_byte_i[FRAME_BITS-1])));

    assert_busy_edge_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rise && !clr_i) |=> ($stable(st_q.cnt) && $stable(st_q.rx_sh) && $stable(st_q.tx_sh)));

    assert_midframe_load_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_i && st_q.cnt != '0 && !acc && !clr_i) |=> $stable(st_q.tx_sh));

    assert_clr_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/sst_busy_ctrl.sv
module sst_busy_ctrl #(
    parameter int BUSY_MAX = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end_i,
    input  logic done_i,
    input  logic clr_i,
    output logic busy_o
);
    localparam int BCNT_W = (BUSY_MAX > 1) ? $clog2(BUSY_MAX) : 1;
    localparam logic [BCNT_W-1:0] HOLD_LAST = BCNT_W'(BUSY_MAX - 1);

    typedef struct packed {
        logic              busy;
        logic [BCNT_W-1:0] cnt;
    } busy_state_t;

    busy_state_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr_i) begin
            b_d = '0;
        end else if (b_q.busy) begin
            if (done_i || b_q.cnt == HOLD_LAST) begin
                b_d = '0;
            end else begin
                b_d.cnt = b_q.cnt + BCNT_W'(1);
            end
        end else if (frame_end_i) begin
            b_d.busy = 1'b1;
            b_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign busy_o = b_q.busy;

    // checker-only run length of the busy window
    logic [BCNT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    assert_busy_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < (BCNT_W+1)'(BUSY_MAX)));

    assert_busy_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && !clr_i && !busy_o) |=> busy_o);

    assert_done_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> !busy_o);
endmodule

// File: rtl/sslave_xcvr.sv
module sslave_xcvr #(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_MAX    = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sclk,
    input  logic                           sdi,
    output logic                           sdo,
    output logic                           busy_n,
    input  logic                           tx_load,
    input  logic [sst_pkg::FRAME_BITS-1:0] tx_byte,
    output logic                           rx_valid,
    output logic [sst_pkg::FRAME_BITS-1:0] rx_byte,
    input  logic                           done,
    input  logic                           frame_clr
);
    logic [1:0] raw_in, sync_out;
    logic frame_end, busy;

    assign raw_in = {sclk, sdi};

    sst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    sst_shift_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sync_out[1]),
        .sdi_s      (sync_out[0]),
        .busy_i     (busy),
        .clr_i      (frame_clr),
        .tx_load_i  (tx_load),
        .tx_byte_i  (tx_byte),
        .frame_end_o(frame_end),
        .sdo_o      (sdo),
        .rx_valid_o (rx_valid),
        .rx_byte_o  (rx_byte)
    );

    sst_busy_ctrl #(.BUSY_MAX(BUSY_MAX)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end_i(frame_end),
        .done_i     (done),
        .clr_i      (frame_clr),
        .busy_o     (busy)
    );

    assign busy_n = ~busy;

    assert_strobe_with_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !busy_n);
endmodule

// File: tb/tb_sslave_xcvr.sv
`timescale 1ns/1ps
module tb_sslave_xcvr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, tx_load = 1'b0, done = 1'b0, frame_clr = 1'b0;
    logic [7:0] tx_byte = '0;
    logic sdo, busy_n, rx_valid;
    logic [7:0] rx_byte;

    always #2.5 clk = ~clk;

    sslave_xcvr dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .busy_n(busy_n), .tx_load(tx_load), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .done(done), .frame_clr(frame_clr)
    );

    int checks = 0, fails = 0;
    int strobes = 0, run = 0, last_run = 0, first_busy = -1;
    logic [7:0] last_rx = '0;
    bit finished = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin strobes++; last_rx = rx_byte; end
            if (!busy_n) run++;
            else if (run != 0) begin last_run = run; run = 0; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_tx(input logic [7:0] v);
        @(negedge clk); tx_load = 1'b1; tx_byte = v;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic send_bit(input logic b, output logic seen);
        @(negedge clk); sclk = 1'b0; sdi = b;
        repeat (4) @(negedge clk);
        seen = sdo;
        sclk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] rxb, input bit use_done, input bit glitch,
                              input bit mid_load, input logic [7:0] mid_val,
                              output logic [7:0] cap);
        bit seen_busy;
        for (int i = 7; i >= 0; i--) begin
            if (mid_load && i == 3) begin
                @(negedge clk); tx_load = 1'b1; tx_byte = mid_val;
                @(negedge clk); tx_load = 1'b0;
            end
            send_bit(rxb[i], cap[i]);
            if (i != 0) repeat (4) @(negedge clk);
        end
        seen_busy  = 0;
        first_busy = -1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            done = 1'b0;
            if (!busy_n && !seen_busy) begin
                seen_busy  = 1;
                first_busy = k;
                if (use_done) done = 1'b1;
                if (glitch) begin
                    sclk = 1'b0;
                    @(negedge clk);
                    sclk = 1'b1;
                    k++;
                end
            end
        end
        done = 1'b0;
    endtask

    // {use_done, tx byte, rx byte}
    localparam logic [16:0] VEC [5] = '{
        {1'b0, 8'hA5, 8'h3C},
        {1'b1, 8'h5A, 8'hC3},
        {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'h81, 8'h7E},
        {1'b0, 8'h00, 8'hFF}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap;
        logic dummy;
        int s0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_n == 1'b1, "R9 busy_n after reset", busy_n, 1);
        check(rx_valid == 1'b0, "R9 rx_valid after reset", rx_valid, 0);
        check(sdo == 1'b0, "R9 sdo after reset", sdo, 0);

        foreach (VEC[j]) begin
            s0 = strobes;
            load_tx(VEC[j][15:8]);
            send_frame(VEC[j][7:0], VEC[j][16], 0, 0, 8'h00, cap);
            check(last_rx == VEC[j][7:0], "R1 received byte", last_rx, VEC[j][7:0]);
            check(strobes == s0 + 1, "R1 one strobe per frame", strobes - s0, 1);
            check(cap == VEC[j][15:8], "R2 transmitted byte", cap, VEC[j][15:8]);
            check(first_busy == 2, "R3 busy onset latency", first_busy, 2);
            if (VEC[j][16]) check(last_run == 1, "R5 done releases busy", last_run, 1);
            else            check(last_run == 6, "R4 busy hold length", last_run, 6);
        end

        // R6: an edge inside the busy window is discarded
        s0 = strobes;
        load_tx(8'h96);
        send_frame(8'h69, 0, 1, 0, 8'h00, cap);
        check(last_rx == 8'h69, "R6 frame before glitch", last_rx, 8'h69);
        check(last_run == 6, "R6 busy unchanged by glitch", last_run, 6);
        load_tx(8'h1E);
        send_frame(8'hE1, 0, 0, 0, 8'h00, cap);
        check(last_rx == 8'hE1, "R6 frame after glitch intact", last_rx, 8'hE1);
        check(cap == 8'h1E, "R6 tx after glitch intact", cap, 8'h1E);
        check(strobes == s0 + 2, "R6 no extra strobe", strobes - s0, 2);

        // R7: a mid-frame load has no effect
        load_tx(8'hC3);
        send_frame(8'h55, 0, 0, 1, 8'h3C, cap);
        check(cap == 8'hC3, "R7 mid-frame load ignored", cap, 8'hC3);
        check(last_rx == 8'h55, "R7 rx alongside ignored load", last_rx, 8'h55);

        // R8: frame_clr after a partial frame
        s0 = strobes;
        for (int b = 0; b < 3; b++) begin
            send_bit(1'b1, dummy);
            repeat (4) @(negedge clk);
        end
        @(negedge clk); frame_clr = 1'b1;
        @(negedge clk); frame_clr = 1'b0;
        load_tx(8'h24);
        send_frame(8'h42, 0, 0, 0, 8'h00, cap);
        check(last_rx == 8'h42, "R8 frame after clear", last_rx, 8'h42);
        check(strobes == s0 + 1, "R8 single strobe after clear", strobes - s0, 1);
        check(cap == 8'h24, "R8 load accepted after clear", cap, 8'h24);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule